// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a tiny processor core with exactly one instruction. Each instruction takes three consecutive memory words that hold the addresses a, b and c. The core reads the word at a and the word at b. It forms b minus a and writes that difference back to address a. If the difference is negative, execution continues at c. Otherwise it continues at the next instruction. Program and data share one word-addressed memory inside the core. That memory is loaded from a parameter image whenever reset is asserted.

The core is meant for housekeeping and initialisation sequences where code density and speed do not matter. Outside the core, only the clock, an active-low reset, a halt flag and the current program counter are visible. A program stops itself by branching to the all-ones address.

Top module: `sbn_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and halt_o reads 0. After each reset the memory again holds the INIT_IMG contents: word i sits at bits [i*DATA_W +: DATA_W].
- R2: An instruction takes exactly 7 clock cycles from the cycle after reset release, or from its previous pc update. pc_o keeps its value during the first 6 of those cycles and changes only at the 7th rising edge.
- R3: The instruction at pc reads its operand addresses from words pc, pc+1 and pc+2, using the low ADDR_W bits of each word. The difference mem[b] - mem[a], taken modulo 2^DATA_W, is written to address a. Later instructions see the new value.
- R4: When bit DATA_W-1 of the difference is 1 and c is not all ones, pc_o becomes c.
- R5: When bit DATA_W-1 of the difference is 0, pc_o becomes pc+3 modulo 2^ADDR_W. A difference of exactly zero counts as not negative.
- R6: Negativity comes only from the sign bit of the truncated difference. For example, 0x8000 - 1 = 0x7FFF with DATA_W=16 is not negative, even though the true difference would overflow.
- R7: When the difference is negative and c is all ones, halt_o goes to 1 at the 7th edge of that instruction. pc_o keeps the address of the halting instruction.
- R8: An all-ones c with a non-negative difference does not halt the core. It advances to pc+3.
- R9: Once halt_o is 1, halt_o and pc_o stay constant until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; reloads the memory image |
| halt_o | output | 1 | High once the program has branched to the all-ones address |
| pc_o | output | ADDR_W | Address of the instruction being executed |

## Verification
The only window into the core is the program counter, so any wrong internal state has to show up as a wrong pc_o or halt_o. A bad operand fetch, a bad difference or a lost write-back changes the sign of a later result. That diverts the program counter at the end of the affected instruction, or at the end of a later instruction that reads the corrupted word, within 7 cycles of that read. A sequencer that skips or repeats a state shifts the moment pc_o changes, which is caught in the same instruction. A memory that is not reloaded on reset turns the final halting instruction into a non-halting one on the second run.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  typedef enum logic [2:0] {
    ST_FA   = 3'd0,  // fetch operand address a
    ST_FB   = 3'd1,  // fetch operand address b
    ST_FC   = 3'd2,  // fetch branch target c
    ST_RA   = 3'd3,  // read mem[a]
    ST_RB   = 3'd4,  // read mem[b]
    ST_WR   = 3'd5,  // write difference to a
    ST_PC   = 3'd6,  // update program counter
    ST_HALT = 3'd7
  } sbn_state_e;
endpackage

// File: rtl/sbn_mem.sv
module sbn_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] INIT_IMG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // image reload on every reset so a program restarts from a known state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= INIT_IMG[i*DATA_W +: DATA_W];
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbn_exec.sv
module sbn_exec #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              neg_i,
  output logic [DATA_W-1:0] diff_o,
  output logic              neg_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              halt_req_o
);
  localparam logic [ADDR_W-1:0] INSN_WORDS = ADDR_W'(3);

  assign diff_o     = op_b_i - op_a_i;
  assign neg_o      = diff_o[DATA_W-1];
  assign next_pc_o  = neg_i ? tgt_i : pc_i + INSN_WORDS;
  assign halt_req_o = neg_i & (&tgt_i);
endmodule

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
  import sbn_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // memory
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  // execute unit
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              neg_o,
  input  logic [DATA_W-1:0] diff_i,
  input  logic              neg_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              halt_req_i,
  output logic              halt_o
);
  sbn_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, a_q, b_q, c_q;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic              neg_q, halt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FA:   state_d = ST_FB;
      ST_FB:   state_d = ST_FC;
      ST_FC:   state_d = ST_RA;
      ST_RA:   state_d = ST_RB;
      ST_RB:   state_d = ST_WR;
      ST_WR:   state_d = ST_PC;
      ST_PC:   state_d = halt_req_i ? ST_HALT : ST_FA;
      default: state_d = ST_HALT;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_FB:   raddr_o = pc_q + ADDR_W'(1);
      ST_FC:   raddr_o = pc_q + ADDR_W'(2);
      ST_RA:   raddr_o = a_q;
      ST_RB:   raddr_o = b_q;
      default: raddr_o = pc_q;
    endcase
  end

  assign we_o    = (state_q == ST_WR);
  assign waddr_o = a_q;
  assign wdata_o = diff_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FA;
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      neg_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_FA: a_q   <= rdata_i[ADDR_W-1:0];
        ST_FB: b_q   <= rdata_i[ADDR_W-1:0];
        ST_FC: c_q   <= rdata_i[ADDR_W-1:0];
        ST_RA: opa_q <= rdata_i;
        ST_RB: opb_q <= rdata_i;
        ST_WR: neg_q <= neg_i;
        ST_PC: begin
          if (halt_req_i) halt_q <= 1'b1;
          else            pc_q   <= next_pc_i;
        end
        default: ;
      endcase
    end
  end

  assign op_a_o = opa_q;
  assign op_b_o = opb_q;
  assign pc_o   = pc_q;
  assign tgt_o  = c_q;
  assign neg_o  = neg_q;
  assign halt_o = halt_q;

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> halt_q); // R9
  AST_PC_FROZEN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> $stable(pc_q)); // R7
  AST_PC_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PC) |=> $stable(pc_q)); // R2
  AST_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R3
  AST_HALT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_q) |-> ($past(neg_q) && ($past(c_q) == '1))); // R7
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PC && !neg_q) |=> (pc_q == $past(pc_q) + ADDR_W'(3))); // R5
endmodule

// File: rtl/sbn_core.sv
module sbn_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT_IMG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              halt_o,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] raddr, waddr, pc, tgt, next_pc;
  logic [DATA_W-1:0] rdata, wdata, op_a, op_b, diff;
  logic              we, neg_cur, neg_reg, halt_req;

  sbn_mem #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH),
    .INIT_IMG(INIT_IMG)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(raddr),
    .rdata_o(rdata),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata)
  );

  sbn_exec #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_exec (
    .op_a_i    (op_a),
    .op_b_i    (op_b),
    .pc_i      (pc),
    .tgt_i     (tgt),
    .neg_i     (neg_reg),
    .diff_o    (diff),
    .neg_o     (neg_cur),
    .next_pc_o (next_pc),
    .halt_req_o(halt_req)
  );

  sbn_ctrl #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_o   (raddr),
    .rdata_i   (rdata),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .op_a_o    (op_a),
    .op_b_o    (op_b),
    .pc_o      (pc),
    .tgt_o     (tgt),
    .neg_o     (neg_reg),
    .diff_i    (diff),
    .neg_i     (neg_cur),
    .next_pc_i (next_pc),
    .halt_req_i(halt_req),
    .halt_o    (halt_o)
  );

  assign pc_o = pc;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (pc_o == '0 && !halt_o)); // R1
  AST_NO_HALT_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !halt_req) |=> !halt_o); // R8
endmodule

// File: tb/sim_sbn_core.sv
module sim_sbn_core;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int HALT_PC = 42;

  function automatic logic [DEPTH*DW-1:0] put(logic [DEPTH*DW-1:0] r, int adr, logic [DW-1:0] v);
    r[adr*DW +: DW] = v;
    return r;
  endfunction

  function automatic logic [DEPTH*DW-1:0] put_ins(logic [DEPTH*DW-1:0] r, int p, int a, int b, int c);
    r = put(r, p, DW'(a));
    r = put(r, p + 1, DW'(b));
    r = put(r, p + 2, DW'(c));
    return r;
  endfunction

  function automatic logic [DEPTH*DW-1:0] build_img();
    logic [DEPTH*DW-1:0] r;
    int unsigned s;
    int n;
    r = '0;
    s = 32'd2463534242;
    r = put_ins(r, 0, 48, 49, 30);   // 5-5 = 0, falls through
    r = put_ins(r, 3, 50, 51, 9);    // 2-7 negative, jumps to 9
    r = put_ins(r, 9, 50, 52, 0);    // 0-(-5) = 5 uses written value
    r = put_ins(r, 12, 53, 54, 63);  // zero with all-ones target
    r = put_ins(r, 15, 55, 56, 0);   // 0x8000-1 wraps positive
    for (int p = 18; p <= 39; p += 3) begin
      n = (HALT_PC - p) / 3;
      s = s * 32'd1664525 + 32'd1013904223;
      r = put(r, p, DW'(48 + (s >> 8) % 14));
      s = s * 32'd1664525 + 32'd1013904223;
      r = put(r, p + 1, DW'(48 + (s >> 8) % 14));
      s = s * 32'd1664525 + 32'd1013904223;
      r = put(r, p + 2, DW'(p + 3 + 3 * int'((s >> 8) % n)));
    end
    r = put_ins(r, HALT_PC, 62, 63, 63);  // 0-1 negative to all ones
    r = put(r, 48, 16'd5);
    r = put(r, 49, 16'd5);
    r = put(r, 50, 16'd7);
    r = put(r, 51, 16'd2);
    r = put(r, 52, 16'd0);
    r = put(r, 53, 16'd3);
    r = put(r, 54, 16'd3);
    r = put(r, 55, 16'd1);
    r = put(r, 56, 16'h8000);
    for (int i = 57; i <= 61; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      r = put(r, i, DW'(s >> 12));
    end
    r = put(r, 62, 16'd1);
    r = put(r, 63, 16'd0);
    return r;
  endfunction

  localparam logic [DEPTH*DW-1:0] IMG = build_img();

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          halt_o;
  logic [AW-1:0] pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] ref_pc;
  bit            ref_halt;

  always #10 clk_i = ~clk_i;

  sbn_core #(.DATA_W(DW), .ADDR_W(AW), .INIT_IMG(IMG)) u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .halt_o(halt_o),
    .pc_o  (pc_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_reset();
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = IMG[i*DW +: DW];
    ref_pc = '0;
    ref_halt = 1'b0;
  endtask

  // one instruction of the reference model; returns the requirement it exercises
  task automatic ref_step(output string tag);
    logic [AW-1:0] a, b, c, pc0;
    logic [DW-1:0] d;
    pc0 = ref_pc;
    a = ref_mem[pc0][AW-1:0];
    b = ref_mem[AW'(pc0 + 1)][AW-1:0];
    c = ref_mem[AW'(pc0 + 2)][AW-1:0];
    d = ref_mem[b] - ref_mem[a];
    ref_mem[a] = d;
    if (d[DW-1]) begin
      if (&c) begin ref_halt = 1'b1; tag = "R7"; end
      else begin ref_pc = c; tag = "R4"; end
    end else begin
      ref_pc = pc0 + AW'(3);
      tag = "R5";
    end
    if (pc0 == 9) tag = "R3";
    if (pc0 == 12) tag = "R8";
    if (pc0 == 15) tag = "R6";
  endtask

  task automatic run_program();
    string tag;
    logic [AW-1:0] prev;
    int n;
    n = 0;
    while (!ref_halt && n < 300) begin
      prev = ref_pc;
      ref_step(tag);
      repeat (6) @(posedge clk_i);
      @(negedge clk_i);
      check("R2", {31'd0, halt_o}, 32'd0);
      check("R2", 32'(pc_o), 32'(prev));
      @(posedge clk_i);
      @(negedge clk_i);
      check(tag, 32'(pc_o), 32'(ref_halt ? prev : ref_pc));
      check(tag, {31'd0, halt_o}, {31'd0, ref_halt});
      n++;
    end
    check("R7", {31'd0, ref_halt}, 32'd1);
  endtask

  initial begin
    int unsigned seed;
    int unsigned cut;
    seed = $urandom(32'd11);
    ref_reset();
    repeat (3) @(negedge clk_i);
    check("R1", 32'(pc_o), 32'd0);
    check("R1", {31'd0, halt_o}, 32'd0);
    rst_ni = 1'b1;
    run_program();
    // halted state must hold
    repeat (25) @(posedge clk_i);
    @(negedge clk_i);
    check("R9", {31'd0, halt_o}, 32'd1);
    check("R9", 32'(pc_o), 32'(HALT_PC));
    // interrupted runs at random points, each followed by a check of the reset state
    for (int k = 0; k < 3; k++) begin
      rst_ni = 1'b0;
      #1;
      check("R1", 32'(pc_o), 32'd0);
      check("R1", {31'd0, halt_o}, 32'd0);
      @(negedge clk_i);
      rst_ni = 1'b1;
      cut = $urandom_range(60, 5);
      repeat (cut) @(posedge clk_i);
      @(negedge clk_i);
    end
    rst_ni = 1'b0;
    #1;
    check("R1", 32'(pc_o), 32'd0);
    check("R1", {31'd0, halt_o}, 32'd0);
    @(negedge clk_i);
    // full rerun: only matches if the memory image was restored (R1)
    ref_reset();
    rst_ni = 1'b1;
    run_program();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule